// File: doc/BRIEF.md
# Endpoint Configuration Header Space

This block holds the 256-byte configuration register space of a single-function endpoint on a PCI-style bus. A host agent reaches it through a plain dword-wide port. Each access carries a 6-bit register number, which selects one 4-byte register, plus four byte enables and a write or read strobe. The space has two parts. The first 64 bytes are the standard type-0 header. The remaining 192 bytes are a device-specific area. Only the first few dwords of that area are backed by storage, and the rest reads as zero.

The header is built from three parts:

- The fixed identity fields: vendor, device, revision, class and header type.
- A command register. Two of its bits gate the endpoint's responses to I/O-space and memory-space accesses.
- One 32-bit memory base address register, sized in the usual way: software writes all ones and reads back the size mask.

An interrupt line byte is also writable, and the interrupt pin byte is fixed. The block's outputs are the decoded enables, the programmed base address, and a hit flag that compares an incoming memory address against that base.

Top module: `cfg_header_space`

## Requirements
- R1: After reset, the command register, io_enable, mem_enable, bar_base, the interrupt line byte and cfg_rdata are all zero.
- R2: Register 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor ID in bits 15:0. The value read in bits 15:0 is never 16'hFFFF.
- R3: Registers 0, 2 and 3 are read-only, and writes to them leave their read value unchanged. Register 2 reads {CLASS_CODE, REVISION_ID}.
- R4: The header type byte is at byte offset 0x0E, which is register 3 bits 23:16. It reads 8'h00: bit 7 is clear (single function) and bits 6:0 give layout 0.
- R5: Command bit 0 drives io_enable and command bit 1 drives mem_enable, each from the clock edge that writes it. Register 1 reads the command in bits 1:0. All other bits read 0, including the status half in bits 31:16.
- R6: Register 4 is the memory base register. Bits BAR_SIZE_LOG2-1:0 always read 0, and bit 0 = 0 marks memory space. Writing 32'hFFFFFFFF and reading back returns the size mask ~(2^BAR_SIZE_LOG2 - 1).
- R7: mem_hit is 1 only when mem_enable is 1 and mem_addr[31:BAR_SIZE_LOG2] equals bar_base[31:BAR_SIZE_LOG2].
- R8: Register 15 bits 7:0 (offset 0x3C) are the read/write interrupt line. Bits 15:8 (offset 0x3D) are the interrupt pin, which is read-only and reads 8'h01.
- R9: On a write, cfg_be[k] alone decides whether byte k (bits 8k+7:8k) of a writable register is updated.
- R10: Registers 16 to 16+DEV_DWORDS-1 are device-specific read/write storage. Every other register number not named above reads 32'h0.
- R11: A read strobe in one cycle loads cfg_rdata at that clock edge. cfg_rdata then holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_regnum | input | 6 | Dword register number (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| mem_addr | input | 32 | Memory address to compare against the base |
| io_enable | output | 1 | I/O-space response enable (command bit 0) |
| mem_enable | output | 1 | Memory-space response enable (command bit 1) |
| bar_base | output | 32 | Programmed memory base register value |
| mem_hit | output | 1 | Memory address falls in the decoded window |

## Verification
The assertions check the following on every cycle:

- The enables follow only writes to the command byte.
- mem_hit never rises without mem_enable.
- The hardwired low bits of the base register stay zero.
- The vendor ID read is never all ones.
- The interrupt pin reads 1.
- Read data holds between read strobes.

The bench's directed scenarios are what show the rest:

- The exact identity values.
- That writes to read-only registers are ignored.
- The size mask returned by an all-ones write.
- Per-byte merging under partial enables.
- The zero reads of unimplemented offsets.
- Address matching at the edges of the window.

// File: rtl/cfg_hdr_pkg.sv
// Package: register numbers and fixed field values shared by the
// configuration header modules. Assumes dword-granular register numbers.
package cfg_hdr_pkg;
    localparam int REGNUM_W  = 6;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;

    localparam logic [REGNUM_W-1:0] REG_IDENT   = 6'd0;
    localparam logic [REGNUM_W-1:0] REG_CMDSTAT = 6'd1;
    localparam logic [REGNUM_W-1:0] REG_CLASS   = 6'd2;
    localparam logic [REGNUM_W-1:0] REG_MISC    = 6'd3;
    localparam logic [REGNUM_W-1:0] REG_BAR0    = 6'd4;
    localparam logic [REGNUM_W-1:0] REG_INTR    = 6'd15;
    localparam int                  DEV_BASE    = 16;

    localparam logic [7:0] HDR_TYPE_SINGLE_T0 = 8'h00;
    localparam logic [7:0] INTR_PIN_A         = 8'h01;
    localparam int         CMD_BITS           = 2;

    typedef struct packed {
        logic              hit;
        logic [DATA_W-1:0] data;
    } rd_src_t;
endpackage

// File: rtl/cfg_ident_regs.sv
// Module: read-only identity registers (vendor/device, revision/class,
// header type). Purely combinational decode; assumes the vendor ID
// parameter is not all ones (an invalid value is replaced with zero).
module cfg_ident_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID   = 16'h0042,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h058000
) (
    input  logic [REGNUM_W-1:0] regnum,
    output rd_src_t             rd
);
    localparam logic [15:0] VENDOR_SAFE = (VENDOR_ID == 16'hFFFF) ? 16'h0000 : VENDOR_ID;

    // Select the fixed value for the addressed identity register.
    always_comb begin
        rd = '0;
        unique case (regnum)
            REG_IDENT: begin
                rd.hit  = 1'b1;
                rd.data = {DEVICE_ID, VENDOR_SAFE};
            end
            REG_CLASS: begin
                rd.hit  = 1'b1;
                rd.data = {CLASS_CODE, REVISION_ID};
            end
            REG_MISC: begin
                rd.hit  = 1'b1;
                rd.data = {8'h00, HDR_TYPE_SINGLE_T0, 8'h00, 8'h00};
            end
            default: rd = '0;
        endcase
    end
endmodule

// File: rtl/cfg_ctrl_regs.sv
// Module: writable header registers: command enables, one memory base
// register with hardwired low bits, and the interrupt line byte. Writes
// take effect at the clock edge of the strobe; byte enables gate each byte.
// Assumes 4 <= BAR_SZ <= 31.
module cfg_ctrl_regs
    import cfg_hdr_pkg::*;
#(
    parameter int BAR_SZ = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [REGNUM_W-1:0] regnum,
    input  logic [BE_W-1:0]     be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   mem_addr,
    output logic                io_en,
    output logic                mem_en,
    output logic [DATA_W-1:0]   bar,
    output logic                hit,
    output rd_src_t             rd
);
    localparam int UPPER_W = DATA_W - BAR_SZ;

    logic [CMD_BITS-1:0] cmd_q;
    logic [UPPER_W-1:0]  bar_hi_q;
    logic [7:0]          intr_line_q;
    logic                unused_ctrl;

    assign unused_ctrl = ^{wdata, mem_addr[BAR_SZ-1:0]};

    // Command register: only the I/O and memory enable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (we && regnum == REG_CMDSTAT && be[0])
            cmd_q <= wdata[CMD_BITS-1:0];
    end

    // Base register upper bits, each updated under its byte's enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bar_hi_q <= '0;
        else if (we && regnum == REG_BAR0)
            for (int i = 0; i < UPPER_W; i++)
                if (be[(i + BAR_SZ) / 8])
                    bar_hi_q[i] <= wdata[i + BAR_SZ];
    end

    // Interrupt line byte, the only writable byte of its register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            intr_line_q <= '0;
        else if (we && regnum == REG_INTR && be[0])
            intr_line_q <= wdata[7:0];
    end

    assign io_en  = cmd_q[0];
    assign mem_en = cmd_q[1];
    assign bar    = {bar_hi_q, {BAR_SZ{1'b0}}};

    // Address window compare, gated by the memory enable.
    always_comb hit = mem_en && (mem_addr[DATA_W-1:BAR_SZ] == bar_hi_q);

    // Read decode for the writable header registers.
    always_comb begin
        rd = '0;
        unique case (regnum)
            REG_CMDSTAT: begin
                rd.hit  = 1'b1;
                rd.data = {{(DATA_W-CMD_BITS){1'b0}}, cmd_q};
            end
            REG_BAR0: begin
                rd.hit  = 1'b1;
                rd.data = bar;
            end
            REG_INTR: begin
                rd.hit  = 1'b1;
                rd.data = {16'h0000, INTR_PIN_A, intr_line_q};
            end
            default: rd = '0;
        endcase
    end
endmodule

// File: rtl/cfg_dev_area.sv
// Module: backed dwords at the start of the device-specific area, each byte
// written under its own enable. Register numbers past the backed range
// return no hit. Assumes DEV_DWORDS <= 48 so the range stays below 256 bytes.
module cfg_dev_area
    import cfg_hdr_pkg::*;
#(
    parameter int DEV_DWORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [REGNUM_W-1:0] regnum,
    input  logic [BE_W-1:0]     be,
    input  logic [DATA_W-1:0]   wdata,
    output rd_src_t             rd
);
    localparam int LAST_REG = DEV_BASE + DEV_DWORDS - 1;

    logic [DATA_W-1:0] mem_q [DEV_DWORDS];

    for (genvar d = 0; d < DEV_DWORDS; d++) begin : g_dword
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            // Store one byte of one device-specific dword.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[d][8*b +: 8] <= '0;
                else if (we && be[b] && int'(regnum) == DEV_BASE + d)
                    mem_q[d][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    // Return the addressed backed dword, if any.
    always_comb begin
        rd = '0;
        for (int d = 0; d < DEV_DWORDS; d++)
            if (int'(regnum) == DEV_BASE + d) begin
                rd.hit  = 1'b1;
                rd.data = mem_q[d];
            end
        if (int'(regnum) > LAST_REG) rd.hit = 1'b0;
    end
endmodule

// File: rtl/cfg_header_space.sv
// Module: top of the type-0 configuration space of a single-function
// endpoint. Combines identity, control and device-area decoders, registers
// read data on the read strobe, and exports the decoded enables and the
// memory window match. Assumes at most one of cfg_we/cfg_re per cycle.
module cfg_header_space
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID     = 16'h0042,
    parameter logic [7:0]  REVISION_ID   = 8'h03,
    parameter logic [23:0] CLASS_CODE    = 24'h058000,
    parameter int          BAR_SIZE_LOG2 = 12,
    parameter int          DEV_DWORDS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_re,
    input  logic [5:0]  cfg_regnum,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] mem_addr,
    output logic        io_enable,
    output logic        mem_enable,
    output logic [31:0] bar_base,
    output logic        mem_hit
);
    rd_src_t rd_ident, rd_ctrl, rd_dev;
    logic [DATA_W-1:0] rd_mux;

    cfg_ident_regs #(
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .REVISION_ID (REVISION_ID),
        .CLASS_CODE  (CLASS_CODE)
    ) u_ident (
        .regnum (cfg_regnum),
        .rd     (rd_ident)
    );

    cfg_ctrl_regs #(
        .BAR_SZ (BAR_SIZE_LOG2)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .regnum   (cfg_regnum),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .mem_addr (mem_addr),
        .io_en    (io_enable),
        .mem_en   (mem_enable),
        .bar      (bar_base),
        .hit      (mem_hit),
        .rd       (rd_ctrl)
    );

    cfg_dev_area #(
        .DEV_DWORDS (DEV_DWORDS)
    ) u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .regnum (cfg_regnum),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .rd     (rd_dev)
    );

    // Merge the decoders; unclaimed register numbers read zero.
    always_comb begin
        rd_mux = '0;
        if (rd_ident.hit) rd_mux = rd_ident.data;
        if (rd_ctrl.hit)  rd_mux = rd_ctrl.data;
        if (rd_dev.hit)   rd_mux = rd_dev.data;
    end

    // Capture read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_re)
            cfg_rdata <= rd_mux;
    end
endmodule

// File: rtl/cfg_header_checker.sv
// Module: assertion checker bound to cfg_header_space; observes ports only.
module cfg_header_checker #(
    parameter int BAR_SZ = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_re,
    input logic [5:0]  cfg_regnum,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        io_enable,
    input logic        mem_enable,
    input logic [31:0] bar_base,
    input logic        mem_hit
);
    logic cmd_wr;
    assign cmd_wr = cfg_we && cfg_regnum == 6'd1 && cfg_be[0];

    AST_IO_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> io_enable == $past(cfg_wdata[0]));                       // R5
    AST_MEM_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> mem_enable == $past(cfg_wdata[1]));                      // R5
    AST_ENABLES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(io_enable) && $stable(mem_enable));             // R5
    AST_HIT_NEEDS_MEM_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> mem_enable);                                            // R7
    AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bar_base[BAR_SZ-1:0] == '0);                                        // R6
    AST_VENDOR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re && cfg_regnum == 6'd0 |=> cfg_rdata[15:0] != 16'hFFFF);      // R2
    AST_INTR_PIN_A: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re && cfg_regnum == 6'd15 |=> cfg_rdata[15:8] == 8'h01);        // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_re |=> $stable(cfg_rdata));                                    // R11
endmodule

bind cfg_header_space cfg_header_checker #(.BAR_SZ(BAR_SIZE_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_re     (cfg_re),
    .cfg_regnum (cfg_regnum),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .io_enable  (io_enable),
    .mem_enable (mem_enable),
    .bar_base   (bar_base),
    .mem_hit    (mem_hit)
);

// File: tb/cfg_header_space_bench.sv
// Directed bench for cfg_header_space: one task per scenario.
module cfg_header_space_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [5:0]  cfg_regnum = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] mem_addr = '0;
    logic        io_enable, mem_enable, mem_hit;
    logic [31:0] bar_base;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    cfg_header_space u_cfg_header_space (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_regnum(cfg_regnum), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_addr(mem_addr), .io_enable(io_enable),
        .mem_enable(mem_enable), .bar_base(bar_base), .mem_hit(mem_hit)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] r, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_regnum = r; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] r, output logic [31:0] d);
        @(negedge clk);
        cfg_re = 1'b1; cfg_regnum = r;
        @(negedge clk);
        cfg_re = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        check("R1 io_enable", {31'b0, io_enable}, 32'h0);
        check("R1 mem_enable", {31'b0, mem_enable}, 32'h0);
        check("R1 bar_base", bar_base, 32'h0);
        check("R1 rdata", cfg_rdata, 32'h0);
        cfg_read(6'd1, v);  check("R1 command", v, 32'h0);
        cfg_read(6'd15, v); check("R1 intr line", {24'h0, v[7:0]}, 32'h0);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        cfg_read(6'd0, v); check("R2 ident", v, 32'h0042A5C3);
        cfg_read(6'd2, v); check("R3 class/rev", v, 32'h05800003);
        cfg_read(6'd3, v); check("R4 header type", {24'h0, v[23:16]}, 32'h0);
        check("R4 misc dword", v, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        cfg_write(6'd0, 4'hF, 32'hFFFFFFFF);
        cfg_write(6'd2, 4'hF, 32'h12345678);
        cfg_write(6'd3, 4'hF, 32'h00FF0000);
        cfg_read(6'd0, v); check("R3 ident after write", v, 32'h0042A5C3);
        cfg_read(6'd2, v); check("R3 class after write", v, 32'h05800003);
        cfg_read(6'd3, v); check("R3 header after write", v, 32'h0);
    endtask

    task automatic t_command;
        logic [31:0] v;
        cfg_write(6'd1, 4'hF, 32'hFFFF_FFFD);
        check("R5 io_enable on", {31'b0, io_enable}, 32'h1);
        check("R5 mem_enable off", {31'b0, mem_enable}, 32'h0);
        cfg_read(6'd1, v); check("R5 command read", v, 32'h1);
        cfg_write(6'd1, 4'hE, 32'h0000_0002);
        check("R9 cmd be0 clear keeps", {30'b0, mem_enable, io_enable}, 32'h1);
        cfg_write(6'd1, 4'h1, 32'h0000_0002);
        check("R5 swap enables", {30'b0, mem_enable, io_enable}, 32'h2);
    endtask

    task automatic t_bar;
        logic [31:0] v;
        cfg_write(6'd4, 4'hF, 32'hFFFFFFFF);
        cfg_read(6'd4, v); check("R6 size mask", v, 32'hFFFFF000);
        cfg_write(6'd4, 4'hF, 32'h8000_0ABC);
        cfg_read(6'd4, v); check("R6 base low bits", v, 32'h80000000);
        cfg_write(6'd4, 4'h8, 32'h4000_0000);
        cfg_read(6'd4, v); check("R9 bar top byte only", v, 32'h40000000);
        cfg_write(6'd4, 4'hF, 32'h8000_0000);
    endtask

    task automatic t_hit;
        cfg_write(6'd1, 4'h1, 32'h0);
        @(negedge clk); mem_addr = 32'h8000_0ABC;
        #1 check("R7 hit gated off", {31'b0, mem_hit}, 32'h0);
        cfg_write(6'd1, 4'h1, 32'h2);
        #1 check("R7 hit in window", {31'b0, mem_hit}, 32'h1);
        mem_addr = 32'h8000_0FFF;
        #1 check("R7 hit top edge", {31'b0, mem_hit}, 32'h1);
        mem_addr = 32'h8000_1000;
        #1 check("R7 miss above", {31'b0, mem_hit}, 32'h0);
        mem_addr = 32'h7FFF_FFFF;
        #1 check("R7 miss below", {31'b0, mem_hit}, 32'h0);
    endtask

    task automatic t_intr;
        logic [31:0] v;
        cfg_write(6'd15, 4'hF, 32'hFFFF_FF5A);
        cfg_read(6'd15, v); check("R8 line and pin", v, 32'h0000015A);
    endtask

    task automatic t_dev_area;
        logic [31:0] v;
        cfg_write(6'd16, 4'hF, 32'h11223344);
        cfg_write(6'd16, 4'h5, 32'hAABBCCDD);
        cfg_read(6'd16, v); check("R9 byte merge", v, 32'h11BB33DD);
        cfg_write(6'd19, 4'hF, 32'hCAFE0001);
        cfg_read(6'd19, v); check("R10 last backed", v, 32'hCAFE0001);
        cfg_write(6'd20, 4'hF, 32'hDEADBEEF);
        cfg_read(6'd20, v); check("R10 past backed", v, 32'h0);
        cfg_write(6'd5, 4'hF, 32'hDEADBEEF);
        cfg_read(6'd5, v);  check("R10 unused header", v, 32'h0);
        cfg_read(6'd63, v); check("R10 last offset", v, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        cfg_read(6'd0, v);
        cfg_write(6'd16, 4'hF, 32'h0);
        repeat (3) @(negedge clk);
        check("R11 rdata holds", cfg_rdata, 32'h0042A5C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_readonly();
        t_command();
        t_bar();
        t_hit();
        t_intr();
        t_dev_area();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule